// File: doc/BRIEF.md
# Double-Banked 8x8 Transpose Store

This block sits between two one-dimensional transform passes. The first pass pushes the coefficients of one square block (8x8 by default) in row order. The second pass pulls them out in column order, so each block leaves the store transposed. Two banks of flip-flops each hold one whole block. While one bank is being filled, the other can be drained, so the two passes overlap at block level. Writes and reads share one clock. One write and one read may complete in the same cycle.

Both sides are valid/ready streams. A write word is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls only while the bank the writer targets still holds an unread block. A producer must then keep offering the word, and the store takes it once that bank is drained. A read word moves on a rising edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and the consumer holds `rd_ready` low, `rd_data` stays steady. A per-bank full flag is brought out as plain status. The block edge `DIM` must be a power of two.

Top module: `tpose_pingpong`

## Requirements
- R1: After reset, `bank_full` is 2'b00, `wr_ready` is 1, `rd_valid` is 0, and both the write side and the read side select bank 0.
- R2: The k-th word accepted into a block (k = 0..63) is stored as element row k/8, column k%8 (row-major fill).
- R3: The j-th word delivered from a block (j = 0..63) is element row j%8, column j/8 of that block (column-major drain). Only a handshake advances the read position.
- R4: Bit b of `bank_full` goes to 1 in the cycle after the 64th write into bank b. It returns to 0 in the cycle after the 64th read from bank b.
- R5: After its 64th write into a bank, the write side moves to the other bank. Block n of the stream lands in bank n%2.
- R6: `wr_ready` is 0 while the write side's target bank is full. Words offered during that time are not stored and do not alter any held block.
- R7: `rd_valid` is 1 only when the read side's bank is full. Blocks are delivered in the order they were filled.
- R8: A write into one bank and a read from the other can complete in the same cycle. This includes one bank's 64th write coinciding with the other bank's 64th read, after which one flag is set and the other is cleared.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write side can accept a word |
| wr_data | input | DATA_W | Signed coefficient, row-major order |
| rd_valid | output | 1 | A full block is available, and `rd_data` holds its next word |
| rd_ready | input | 1 | Read request |
| rd_data | output | DATA_W | Signed coefficient, column-major order |
| bank_full | output | 2 | Per-bank full flag, bit b for bank b |

## Verification
The two functions that can coincide are the write into one bank and the drain of the other, and in the hardest case both finish their 64th word on the same edge. The bench provokes this by filling one block, then streaming the next block in while the first streams out, with no gaps on either side, so both finish together. It judges the result by the `bank_full` pattern that follows and by the order and content of the next block read. Further sweeps run both streams with differing idle patterns. They also hold write data against a full store to show that the offered words leave no trace.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  localparam int NBANK = 2;
  typedef logic bank_sel_t;
endpackage

// File: rtl/tpose_seq_ctrl.sv
module tpose_seq_ctrl #(
  parameter int DIM       = 8,
  parameter bit COL_MAJOR = 1'b0,
  localparam int NUM      = DIM * DIM,
  localparam int DW       = $clog2(DIM),
  localparam int CW       = $clog2(NUM)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output tpose_pkg::bank_sel_t bank,
  output logic [CW-1:0]       addr,
  output logic                last
);
  logic [CW-1:0] cnt_q;
  tpose_pkg::bank_sel_t bank_q;

  assign last = step && (cnt_q == CW'(NUM - 1));
  assign bank = bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else if (step) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (last) bank_q <= ~bank_q;
    end
  end

  generate
    if (COL_MAJOR) begin : g_col
      // count low bits walk rows, high bits walk columns
      assign addr = {cnt_q[DW-1:0], cnt_q[CW-1:DW]};
    end else begin : g_row
      assign addr = cnt_q;
    end
  endgenerate

  assert_bank_flip_R5: assert property (@(posedge clk) disable iff (rst)
    last |=> (bank_q != $past(bank_q)));
endmodule

// File: rtl/tpose_store.sv
module tpose_store #(
  parameter int DATA_W = 16,
  parameter int DIM    = 8,
  localparam int NUM   = DIM * DIM,
  localparam int CW    = $clog2(NUM)
) (
  input  logic                     clk,
  input  logic                     we,
  input  tpose_pkg::bank_sel_t     wbank,
  input  logic [CW-1:0]            waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  tpose_pkg::bank_sel_t     rbank,
  input  logic [CW-1:0]            raddr,
  output logic signed [DATA_W-1:0] rdata
);
  logic signed [DATA_W-1:0] mem [tpose_pkg::NBANK][NUM];

  always_ff @(posedge clk) begin
    if (we) mem[wbank][waddr] <= wdata;
  end

  assign rdata = mem[rbank][raddr];
endmodule

// File: rtl/tpose_pingpong.sv
module tpose_pingpong #(
  parameter int DATA_W = 16,
  parameter int DIM    = 8,
  localparam int NUM   = DIM * DIM,
  localparam int CW    = $clog2(NUM)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic signed [DATA_W-1:0] wr_data,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic signed [DATA_W-1:0] rd_data,
  output logic [1:0]               bank_full
);
  logic wr_fire, rd_fire, wr_last, rd_last;
  tpose_pkg::bank_sel_t wr_bank, rd_bank;
  logic [CW-1:0] wr_addr, rd_addr;
  logic [tpose_pkg::NBANK-1:0] full_q;

  assign wr_ready  = !full_q[wr_bank];
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_valid  = full_q[rd_bank];
  assign rd_fire   = rd_valid && rd_ready;
  assign bank_full = full_q;

  tpose_seq_ctrl #(.DIM(DIM), .COL_MAJOR(1'b0)) u_wr (
    .clk(clk), .rst(rst), .step(wr_fire),
    .bank(wr_bank), .addr(wr_addr), .last(wr_last));

  tpose_seq_ctrl #(.DIM(DIM), .COL_MAJOR(1'b1)) u_rd (
    .clk(clk), .rst(rst), .step(rd_fire),
    .bank(rd_bank), .addr(rd_addr), .last(rd_last));

  tpose_store #(.DATA_W(DATA_W), .DIM(DIM)) u_store (
    .clk(clk), .we(wr_fire), .wbank(wr_bank), .waddr(wr_addr), .wdata(wr_data),
    .rbank(rd_bank), .raddr(rd_addr), .rdata(rd_data));

  generate
    for (genvar b = 0; b < tpose_pkg::NBANK; b++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) full_q[b] <= 1'b0;
        else if (wr_last && wr_bank == 1'(b)) full_q[b] <= 1'b1;
        else if (rd_last && rd_bank == 1'(b)) full_q[b] <= 1'b0;
      end

      assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(full_q[b]) |-> $past(wr_last && wr_bank == 1'(b)));
      assert_flag_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q[b]) |-> $past(rd_last && rd_bank == 1'(b)));
    end
  endgenerate

  assert_split_banks_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && rd_fire) |-> (wr_bank != rd_bank));
  assert_fill_order_R7: assert property (@(posedge clk) disable iff (rst)
    (full_q == '0) |-> (wr_bank == rd_bank));
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> $stable(rd_data));
endmodule

// File: tb/tpose_pingpong_bench.sv
module tpose_pingpong_bench;
  localparam int PERIOD = 10;
  localparam int DIM = 8;
  localparam int NUM = DIM * DIM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic signed [15:0] wr_data = '0;
  logic wr_ready, rd_valid;
  logic signed [15:0] rd_data;
  logic [1:0] bank_full;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  tpose_pingpong #(.DATA_W(16), .DIM(DIM)) u_tpose_pingpong (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .bank_full(bank_full));

  function automatic logic [15:0] elem(int blk, int idx);
    logic [15:0] v = 16'((blk << 8) | idx);
    return (blk % 2 == 1) ? (v ^ 16'h8000) : v;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] d);
    logic got;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    forever begin
      got = wr_ready;
      @(posedge clk);
      if (got) break;
      @(negedge clk);
    end
  endtask

  task automatic pop(output logic [15:0] d);
    logic v;
    @(negedge clk);
    rd_ready = 1'b1;
    forever begin
      v = rd_valid; d = rd_data;
      @(posedge clk);
      if (v) break;
      @(negedge clk);
    end
  endtask

  // gap: 0 none, else idle one cycle when index % gap == gap-1
  task automatic write_block(int blk, int gap);
    for (int i = 0; i < NUM; i++) begin
      if (gap != 0 && i % gap == gap - 1) begin @(negedge clk); wr_valid = 1'b0; end
      push(elem(blk, i));
    end
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic read_block(int blk, int gap);
    logic [15:0] d;
    for (int j = 0; j < NUM; j++) begin
      if (gap != 0 && j % gap == gap - 1) begin @(negedge clk); rd_ready = 1'b0; end
      pop(d);
      // R3 transpose: j-th word is row j%8, col j/8; R2: stored at row*8+col
      chk("R3/R2/R7 data", d, elem(blk, (j % DIM) * DIM + (j / DIM)));
    end
    @(negedge clk); rd_ready = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 bank_full", 16'(bank_full), 16'h0);
    chk("R1 wr_ready", 16'(wr_ready), 16'h1);
    chk("R1 rd_valid", 16'(rd_valid), 16'h0);

    write_block(0, 5);
    chk("R4 flag set bank0", 16'(bank_full), 16'h1);
    chk("R7 rd_valid", 16'(rd_valid), 16'h1);
    chk("R5 next bank free", 16'(wr_ready), 16'h1);

    write_block(1, 0);
    chk("R4 both full", 16'(bank_full), 16'h3);
    // R6: offer junk while full
    for (int c = 0; c < 6; c++) begin
      wr_valid = 1'b1; wr_data = 16'hdead;
      @(negedge clk);
      chk("R6 wr_ready low", 16'(wr_ready), 16'h0);
    end
    wr_valid = 1'b0;

    // R9: hold with rd_ready low, data steady
    begin
      logic [15:0] h;
      h = rd_data;
      repeat (3) @(negedge clk);
      chk("R9 hold", rd_data, h);
    end

    read_block(0, 3);   // R6: junk did not alter block 0
    chk("R4 flag clear bank0", 16'(bank_full), 16'h2);
    chk("R5 writer back to bank0", 16'(wr_ready), 16'h1);

    // R8: simultaneous last write (bank0) and last read (bank1)
    fork
      write_block(2, 0);
      read_block(1, 0);
    join
    chk("R8 flags after coincident finish", 16'(bank_full), 16'h1);
    read_block(2, 0);
    chk("R4 all empty", 16'(bank_full), 16'h0);
    chk("R7 rd_valid empty", 16'(rd_valid), 16'h0);

    // sweep overlapping streams with differing idle patterns
    for (int p = 0; p < 3; p++) begin
      fork
        begin
          for (int b = 0; b < 4; b++) write_block(10 + p * 4 + b, (p + b) % 4);
        end
        begin
          for (int b = 0; b < 4; b++) read_block(10 + p * 4 + b, (p * 2 + b) % 5);
        end
      join
      chk("R4 empty after sweep", 16'(bank_full), 16'h0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule